// File: doc/BRIEF.md
# Prescaled Dual Timer with Watchdog

This block is a timer unit for a processor subsystem. A single 10-bit prescaler divides the system clock into a common tick, and that tick steps two 24-bit general-purpose down-counters and one 24-bit watchdog counter. The timers, the prescaler and the watchdog therefore all advance at the same rate.

Each general timer can run periodically, reloading itself after every underflow, or as a one-shot that stops after its first underflow. Each underflow produces a single-cycle interrupt pulse for an interrupt controller outside this block. The watchdog counts down from a value written by software. When it reaches zero it drives an active-low timeout output, which stays low until software writes a new count or the unit is reset.

Software reaches every register through a flat write/read port. A write takes one clock cycle, and reads are combinational from the address.

Top module: `prescaled_timer_unit`

## Requirements
- R1: While reset is held, and right after it is released, the following values apply. The prescaler reload reads 0. Both timer counters, reload registers and control fields read 0. The irq lines are low and wdog_n is high. The watchdog count reads 0xFFFFFF while reset is asserted.
- R2: With prescaler reload P, the shared tick fires once every P+1 clock cycles. Writing the reload (address 0, bits 9:0) also restarts the prescaler count from the new value.
- R3: An enabled timer's counter decreases by one on each tick. A disabled timer's counter holds its value.
- R4: A tick that finds an enabled timer at zero is an underflow. It produces a one-cycle pulse on that timer's irq bit. In periodic mode the counter reloads, so with timer reload R the pulses repeat every (R+1)*(P+1) cycles.
- R5: In one-shot mode an underflow clears the timer's enable bit and leaves the counter at zero. No further pulse follows.
- R6: Writing the timer control register with bit 2 (load) set copies the reload value into the counter in that same write. Bit 2 always reads back as 0.
- R7: The register map is as follows. Address 0 holds the prescaler reload. Timer i uses base 1+3*i, with the counter at base+0, the reload at base+1 and the control at base+2. Control bit 0 is enable and bit 1 is periodic. The watchdog count is at address 7. Unmapped addresses read 0, and the counter can be written directly.
- R8: The watchdog count decreases by one on each tick and stops at zero. wdog_n is low exactly while the count is zero.
- R9: Writing the watchdog count restarts it, and wdog_n returns high in the cycle after a nonzero write.
- R10: A write to a timer's counter or control register in the same cycle as a tick takes precedence, and that tick is not applied to the timer. The same holds for a watchdog write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 24 | Register write data |
| rdata | output | 24 | Register read data, combinational from addr |
| irq | output | 2 | One-cycle underflow pulse per timer |
| wdog_n | output | 1 | Active-low watchdog timeout |

## Verification
The checker watches several properties on every cycle:
- Each interrupt pulse follows a prescaler tick.
- A one-shot underflow leaves its timer disabled.
- The tick is a single-cycle pulse whenever the reload is nonzero.
- The watchdog count moves only on a tick or a write.
- A low timeout stays low until the count is written.
- A nonzero write releases the timeout in the next cycle.

Only the bench scenarios can show the following:
- The exact interrupt periods for different pairings of prescaler and reload values.
- The reset values and the register map.
- The effect of the load bit.
- The write-over-tick priority.
- The exact cycle on which the watchdog reaches zero.

// File: rtl/tu_pkg.sv
`timescale 1ns/1ps
package tu_pkg;
  localparam int unsigned PRESC_ADDR     = 0;
  localparam int unsigned REGS_PER_TIMER = 3;
  localparam int unsigned OFS_COUNT      = 0;
  localparam int unsigned OFS_RELOAD     = 1;
  localparam int unsigned OFS_CTRL       = 2;

  typedef struct packed {
    logic load;
    logic periodic;
    logic enable;
  } tmr_ctrl_t;

  function automatic int unsigned timer_base(input int unsigned idx);
    return 1 + REGS_PER_TIMER * idx;
  endfunction

  function automatic int unsigned wdog_addr(input int unsigned n_timers);
    return 1 + REGS_PER_TIMER * n_timers;
  endfunction
endpackage

// File: rtl/tu_rst_sync.sv
`timescale 1ns/1ps
module tu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tu_prescaler.sv
`timescale 1ns/1ps
module tu_prescaler #(
  parameter int unsigned PRESC_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reload_wr,
  input  logic [PRESC_W-1:0] reload_val,
  output logic [PRESC_W-1:0] reload_q,
  output logic               tick
);
  logic [PRESC_W-1:0] cnt_q, cnt_d, reload_d;

  assign tick = (cnt_q == '0);

  always_comb begin
    reload_d = reload_q;
    cnt_d    = cnt_q;
    if (reload_wr) begin
      reload_d = reload_val;
      cnt_d    = reload_val;
    end else if (tick) begin
      cnt_d = reload_q;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
    end else begin
      reload_q <= reload_d;
      cnt_q    <= cnt_d;
    end
  end
endmodule

// File: rtl/tu_gp_timer.sv
`timescale 1ns/1ps
module tu_gp_timer import tu_pkg::*; #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic             rel_wr,
  input  logic             ctl_wr,
  input  logic [CNT_W-1:0] wval,
  input  tmr_ctrl_t        ctl_in,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] rel_q,
  output logic             en_q,
  output logic             per_q,
  output logic             irq_q
);
  logic [CNT_W-1:0] cnt_d, rel_d;
  logic             en_d, per_d, irq_d;

  always_comb begin
    cnt_d = cnt_q;
    rel_d = rel_q;
    en_d  = en_q;
    per_d = per_q;
    irq_d = 1'b0;
    if (rel_wr) rel_d = wval;
    if (cnt_wr) begin
      cnt_d = wval;
    end else if (ctl_wr) begin
      en_d  = ctl_in.enable;
      per_d = ctl_in.periodic;
      if (ctl_in.load) cnt_d = rel_q;
    end else if (tick && en_q) begin
      if (cnt_q == '0) begin
        irq_d = 1'b1;
        if (per_q) cnt_d = rel_q;
        else       en_d  = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= '0;
      en_q  <= 1'b0;
      per_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rel_q <= rel_d;
      en_q  <= en_d;
      per_q <= per_d;
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/tu_watchdog.sv
`timescale 1ns/1ps
module tu_watchdog #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expired_n
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_wr)                   cnt_d = load_val;
    else if (tick && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '1;
      expired_n <= 1'b1;
    end else begin
      cnt_q     <= cnt_d;
      expired_n <= (cnt_d != '0);
    end
  end
endmodule

// File: rtl/prescaled_timer_unit.sv
`timescale 1ns/1ps
module prescaled_timer_unit import tu_pkg::*; #(
  parameter int unsigned PRESC_W    = 10,
  parameter int unsigned CNT_W      = 24,
  parameter int unsigned NUM_TIMERS = 2,
  parameter int unsigned ADDR_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [CNT_W-1:0]      wdata,
  output logic [CNT_W-1:0]      rdata,
  output logic [NUM_TIMERS-1:0] irq,
  output logic                  wdog_n
);
  localparam logic [ADDR_W-1:0] WDOG_A  = ADDR_W'(wdog_addr(NUM_TIMERS));
  localparam logic [ADDR_W-1:0] PRESC_A = ADDR_W'(PRESC_ADDR);

  logic                  rst_sync_n;
  logic                  tick;
  logic [PRESC_W-1:0]    presc_rel;
  logic [CNT_W-1:0]      tmr_cnt [NUM_TIMERS];
  logic [CNT_W-1:0]      tmr_rel [NUM_TIMERS];
  logic [NUM_TIMERS-1:0] tmr_en, tmr_per;
  logic [CNT_W-1:0]      wdog_cnt;
  tmr_ctrl_t             ctl_in;

  assign ctl_in = tmr_ctrl_t'(wdata[2:0]);

  tu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  tu_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_sync_n),
    .reload_wr(wr_en && addr == PRESC_A),
    .reload_val(wdata[PRESC_W-1:0]),
    .reload_q(presc_rel), .tick(tick)
  );

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(timer_base(g));
    tu_gp_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_sync_n), .tick(tick),
      .cnt_wr(wr_en && addr == BASE + ADDR_W'(OFS_COUNT)),
      .rel_wr(wr_en && addr == BASE + ADDR_W'(OFS_RELOAD)),
      .ctl_wr(wr_en && addr == BASE + ADDR_W'(OFS_CTRL)),
      .wval(wdata), .ctl_in(ctl_in),
      .cnt_q(tmr_cnt[g]), .rel_q(tmr_rel[g]),
      .en_q(tmr_en[g]), .per_q(tmr_per[g]), .irq_q(irq[g])
    );
  end

  tu_watchdog #(.CNT_W(CNT_W)) u_wdog (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick),
    .load_wr(wr_en && addr == WDOG_A), .load_val(wdata),
    .cnt_q(wdog_cnt), .expired_n(wdog_n)
  );

  always_comb begin
    rdata = '0;
    if (addr == PRESC_A) rdata = CNT_W'(presc_rel);
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (addr == ADDR_W'(timer_base(i) + OFS_COUNT))  rdata = tmr_cnt[i];
      if (addr == ADDR_W'(timer_base(i) + OFS_RELOAD)) rdata = tmr_rel[i];
      if (addr == ADDR_W'(timer_base(i) + OFS_CTRL))
        rdata = CNT_W'({tmr_per[i], tmr_en[i]});
    end
    if (addr == WDOG_A) rdata = wdog_cnt;
  end
endmodule

// File: rtl/tu_checker.sv
`timescale 1ns/1ps
module tu_checker import tu_pkg::*; #(
  parameter int unsigned PRESC_W    = 10,
  parameter int unsigned CNT_W      = 24,
  parameter int unsigned NUM_TIMERS = 2,
  parameter int unsigned ADDR_W     = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     addr,
  input logic [CNT_W-1:0]      wdata,
  input logic [PRESC_W-1:0]    presc_rel,
  input logic [NUM_TIMERS-1:0] irq,
  input logic [NUM_TIMERS-1:0] en,
  input logic [NUM_TIMERS-1:0] per,
  input logic                  wdog_n,
  input logic [CNT_W-1:0]      wdog_cnt
);
  logic wr_wdog, wr_presc;
  assign wr_wdog  = wr_en && addr == ADDR_W'(wdog_addr(NUM_TIMERS));
  assign wr_presc = wr_en && addr == ADDR_W'(PRESC_ADDR);

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_chk
    a_r4_irq_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |-> $past(tick));
    a_r5_oneshot_disables: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[g] && !per[g]) |-> !en[g]);
  end

  a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && presc_rel != '0 && !wr_presc) |=> !tick);

  a_r8_wdog_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_wdog) |=> $stable(wdog_cnt));

  a_r8_timeout_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdog_n && !wr_wdog) |=> !wdog_n);

  a_r9_restart_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_wdog && wdata != '0) |=> wdog_n);
endmodule

bind prescaled_timer_unit tu_checker #(
  .PRESC_W(PRESC_W), .CNT_W(CNT_W), .NUM_TIMERS(NUM_TIMERS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tick(tick), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .presc_rel(presc_rel), .irq(irq), .en(tmr_en), .per(tmr_per),
  .wdog_n(wdog_n), .wdog_cnt(wdog_cnt)
);

// File: tb/tb_prescaled_timer_unit.sv
`timescale 1ns/1ps
module tb_prescaled_timer_unit;
  localparam logic [3:0] A_PRE = 4'd0, A_WD = 4'd7;
  localparam int NV = 7;
  // {timer[50], presc reload[49:40], timer reload[39:16], expected period[15:0]}
  localparam logic [50:0] VEC [NV] = '{
    {1'b0, 10'd0,    24'd0, 16'd1},
    {1'b1, 10'd0,    24'd3, 16'd4},
    {1'b0, 10'd2,    24'd1, 16'd6},
    {1'b1, 10'd4,    24'd4, 16'd25},
    {1'b0, 10'd9,    24'd2, 16'd30},
    {1'b1, 10'd1,    24'd0, 16'd2},
    {1'b0, 10'd1023, 24'd1, 16'd2048}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0]  addr  = '0;
  logic [23:0] wdata = '0;
  logic [23:0] rdata;
  logic [1:0]  irq;
  logic        wdog_n;
  int nchk = 0, nerr = 0, cyc = 0;

  prescaled_timer_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .wdog_n(wdog_n)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nerr++;
      $display("FAIL watchdog: run hung at cycle %0d", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [23:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [23:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_irq(input int t, output int at, output bit ok);
    ok = 1'b0; at = 0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (irq[t]) begin at = cyc; ok = 1'b1; break; end
    end
  endtask

  initial begin
    logic [23:0] v, hold;
    int t1, t2, pulses;
    bit ok1, ok2;

    // R1: values during and after reset
    repeat (3) @(negedge clk);
    rd(A_WD, v);          chk("R1 wdog count in reset", v, 24'hFFFFFF);
    chk("R1 wdog_n in reset", wdog_n, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(A_PRE, v);         chk("R1 presc reload", v, 0);
    rd(4'd1, v);          chk("R1 t0 count", v, 0);
    rd(4'd5, v);          chk("R1 t1 reload", v, 0);
    rd(4'd6, v);          chk("R1 t1 ctrl", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 wdog_n", wdog_n, 1);

    // R2 R4: periodic interrupt periods from the vector table
    for (int i = 0; i < NV; i++) begin
      int tt;
      logic [3:0] base;
      tt   = int'(VEC[i][50]);
      base = 4'(1 + 3 * tt);
      wr(A_PRE, 24'(VEC[i][49:40]));
      wr(base + 4'd1, VEC[i][39:16]);
      wr(base + 4'd2, 24'h7);
      wait_irq(tt, t1, ok1);
      wait_irq(tt, t2, ok2);
      chk("R2 R4 irq seen", {30'd0, ok1, ok2}, 32'd3);
      chk("R2 R4 period", t2 - t1, 32'(VEC[i][15:0]));
      wr(base + 4'd2, 24'h0);
    end

    // R7: register map readback and unmapped address
    wr(4'd2, 24'hABCDE);
    rd(4'd2, v);           chk("R7 t0 reload readback", v, 24'hABCDE);
    rd(4'd15, v);          chk("R7 unmapped reads 0", v, 0);
    rd(A_PRE, v);          chk("R7 presc reload readback", v, 24'd1023);

    // R6: load bit copies the reload, reads back 0
    wr(A_PRE, 24'd0);
    wr(4'd2, 24'd100);
    wr(4'd3, 24'h4);
    rd(4'd1, v);           chk("R6 load copies reload", v, 100);
    rd(4'd3, v);           chk("R6 load bit reads 0", v, 0);

    // R10 R3: counter write beats the tick, then decrements
    wr(4'd3, 24'h3);
    wr(4'd1, 24'd50);
    rd(4'd1, v);           chk("R10 write beats tick", v, 50);
    @(posedge clk); @(negedge clk);
    rd(4'd1, v);           chk("R3 decrement per tick", v, 49);
    wr(4'd3, 24'h0);
    rd(4'd1, hold);
    repeat (5) @(negedge clk);
    rd(4'd1, v);           chk("R3 disabled holds", v, hold);

    // R5: one-shot on timer 1
    wr(4'd5, 24'd3);
    wr(4'd6, 24'h5);
    wait_irq(1, t1, ok1);
    chk("R5 one-shot fires", ok1, 1);
    @(negedge clk);
    rd(4'd6, v);           chk("R5 enable cleared", v, 0);
    rd(4'd4, v);           chk("R5 count stays 0", v, 0);
    pulses = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (irq[1]) pulses++;
    end
    chk("R5 no further pulse", pulses, 0);

    // R8 R9: watchdog expiry and restart
    wr(A_WD, 24'd5);
    rd(A_WD, v);           chk("R9 wdog count loaded", v, 5);
    chk("R9 wdog_n high after load", wdog_n, 1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R8 wdog_n high at count 1", wdog_n, 1);
    @(posedge clk); @(negedge clk);
    chk("R8 wdog_n low at zero", wdog_n, 0);
    repeat (20) @(negedge clk);
    chk("R8 wdog_n held low", wdog_n, 0);
    rd(A_WD, v);           chk("R8 count stops at 0", v, 0);
    wr(A_WD, 24'd3);
    chk("R9 restart releases", wdog_n, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 expires again", wdog_n, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule